// File: doc/BRIEF.md
# ADC Result Interrupt and Threshold Monitor

This block sits behind a 12-channel, 12-bit converter sequencer. It watches the stream of finished conversions and raises interrupt and DMA requests from it. Each result arrives as a one-cycle valid strobe together with its channel number, its value and the sequence (A or B) that produced it. For each sequence, a level input gives that sequence's mode: per-conversion requests or end-of-sequence requests. Each sequence also provides an end-of-sequence strobe. Overrun indications come in once per channel data register and once per sequence global register.

A small write-only register file configures the block. It holds an enable word, one upper and one lower threshold shared by all channels, and a sticky per-channel threshold flag register that is cleared by writing ones. Every channel has a 2-bit compare mode. The mode selects an out-of-window test, a test for a crossing of the lower threshold, or no test. The flag vector is also brought out as a port, so the state that software would read can be observed.

Top module: `adc_irq_gen`

## Requirements
- R1: After reset every register is 0 and all outputs are 0. Writes go to address 0 (enable), 1 (upper threshold, low RES_W bits), 2 (lower threshold) and 3 (flag clear). In the enable word, bit 0 gates sequence A, bit 1 gates sequence B, bit 2 gates overrun, and bits [4+2n:3+2n] hold the compare mode of channel n.
- R2: In compare mode 1, a result on channel n above the upper threshold or below the lower threshold sets flag n on the next clock edge. A result equal to either threshold does not set it.
- R3: In compare mode 2, flag n is set when the result's below-lower state differs from that of channel n's previous result. The first result on a channel after reset only records history. History is updated by every valid result, whatever the mode.
- R4: Compare modes 0 and 3 never set a flag.
- R5: Flags are sticky. Writing 1 to a bit at address 3 clears it and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set. `thr_irq` is the OR of all flags.
- R6: With its enable bit set and mode 0, a sequence gives a one-cycle request in the cycle after each of its results. With mode 1, it gives a request only in the cycle after its end-of-sequence strobe. With the enable bit clear, it gives none.
- R7: With enable bit 2 set, `ovr_irq` pulses in the cycle after any channel overrun. A global overrun of sequence s counts only while that sequence's mode is 0. With bit 2 clear, there is no pulse.
- R8: The threshold compare of a channel does not depend on which sequence produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | Result valid strobe |
| res_chan | input | CH_W (4) | Channel of the result |
| res_data | input | RES_W (12) | Conversion value |
| res_seq | input | 1 | Sequence of the result, 0 = A, 1 = B |
| seq_mode | input | 2 | Per-sequence mode, 1 = end-of-sequence requests |
| seq_eos | input | 2 | End-of-sequence strobes |
| chan_ovr | input | NUM_CH (12) | Channel data register overrun |
| glob_ovr | input | 2 | Global register overrun per sequence |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | REG_W (27) | Write data |
| seq_irq | output | 2 | Sequence A/B interrupt or DMA request |
| ovr_irq | output | 1 | Overrun interrupt request |
| thr_irq | output | 1 | Threshold-compare interrupt request |
| thr_flag | output | NUM_CH (12) | Threshold flag register contents |

## Verification
The checker assumes that a valid result always names a channel below NUM_CH. Its per-channel properties depend on that, because they index the enable word and the flag vector with the incoming channel number. The bench uses channels 3 to 7 only. It changes inputs on the falling edge and keeps each strobe high for exactly one cycle. It clears flags before each scenario, so that every sticky-flag property begins from a known value.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
   typedef enum logic [1:0] {
      CMP_OFF     = 2'd0,
      CMP_OUTSIDE = 2'd1,
      CMP_CROSS   = 2'd2,
      CMP_RSVD    = 2'd3
   } cmp_mode_e;

   localparam int unsigned ADDR_W  = 2;
   localparam int unsigned NUM_SEQ = 2;

   localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
   localparam logic [ADDR_W-1:0] A_HIGH   = 2'd1;
   localparam logic [ADDR_W-1:0] A_LOW    = 2'd2;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd3;

   localparam int unsigned EN_OVR     = 2;
   localparam int unsigned EN_CMP_LSB = 3;
endpackage

// File: rtl/adc_irq_regs.sv
module adc_irq_regs import adc_irq_pkg::*; #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned RES_W  = 12,
   parameter int unsigned REG_W  = 27
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    en_q,
   output logic [RES_W-1:0]    high_q,
   output logic [RES_W-1:0]    low_q,
   output logic [NUM_CH-1:0]   flag_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         high_q <= '0;
         low_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_ENABLE: en_q   <= wr_data;
            A_HIGH:   high_q <= wr_data[RES_W-1:0];
            A_LOW:    low_q  <= wr_data[RES_W-1:0];
            default:  ;
         endcase
      end
   end

   assign flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NUM_CH-1:0] : '0;
endmodule

// File: rtl/adc_thr_chan.sv
module adc_thr_chan import adc_irq_pkg::*; #(
   parameter int unsigned RES_W         = 12,
   parameter bit          CROSS_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [RES_W-1:0] data,
   input  logic [RES_W-1:0] high,
   input  logic [RES_W-1:0] low,
   input  cmp_mode_e        mode,
   input  logic             clr,
   output logic             flag
);
   logic below_now;
   logic outside;
   logic crossed;
   logic set_cond;

   assign below_now = data < low;
   assign outside   = below_now || (data > high);

   generate
      if (CROSS_SUPPORT) begin : g_cross
         logic below_q;
         logic hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               below_q <= 1'b0;
               hist_q  <= 1'b0;
            end else if (hit) begin
               below_q <= below_now;
               hist_q  <= 1'b1;
            end
         end
         assign crossed = hist_q && (below_q != below_now);
      end else begin : g_nocross
         assign crossed = 1'b0;
      end
   endgenerate

   always_comb begin
      case (mode)
         CMP_OUTSIDE: set_cond = outside;
         CMP_CROSS:   set_cond = crossed;
         default:     set_cond = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (hit && set_cond) || (flag && !clr);
   end
endmodule

// File: rtl/adc_seq_req.sv
module adc_seq_req (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic eos_mode,
   input  logic conv_done,
   input  logic seq_end,
   output logic req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= enable && (eos_mode ? seq_end : conv_done);
   end
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen import adc_irq_pkg::*; #(
   parameter int unsigned NUM_CH        = 12,
   parameter int unsigned RES_W         = 12,
   parameter int unsigned REG_W         = 3 + 2*NUM_CH,
   parameter bit          CROSS_SUPPORT = 1'b1,
   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                res_vld,
   input  logic [CH_W-1:0]     res_chan,
   input  logic [RES_W-1:0]    res_data,
   input  logic                res_seq,
   input  logic [1:0]          seq_mode,
   input  logic [1:0]          seq_eos,
   input  logic [NUM_CH-1:0]   chan_ovr,
   input  logic [1:0]          glob_ovr,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   output logic [1:0]          seq_irq,
   output logic                ovr_irq,
   output logic                thr_irq,
   output logic [NUM_CH-1:0]   thr_flag
);
   localparam int unsigned EN_W = EN_CMP_LSB + 2*NUM_CH;

   if (REG_W < EN_W) begin : g_bad_regw
      $error("REG_W too narrow for the enable word");
   end
   if (REG_W < RES_W) begin : g_bad_resw
      $error("REG_W narrower than RES_W");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end

   logic [REG_W-1:0]  en_q;
   logic [RES_W-1:0]  high_q;
   logic [RES_W-1:0]  low_q;
   logic [NUM_CH-1:0] flag_clr;
   logic              glob_hit;
   logic              ovr_q;

   adc_irq_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W), .REG_W(REG_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .en_q     (en_q),
      .high_q   (high_q),
      .low_q    (low_q),
      .flag_clr (flag_clr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      cmp_mode_e mode_i;
      assign mode_i = cmp_mode_e'(en_q[EN_CMP_LSB + 2*i +: 2]);
      adc_thr_chan #(.RES_W(RES_W), .CROSS_SUPPORT(CROSS_SUPPORT)) i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (res_vld && res_chan == CH_W'(i)),
         .data  (res_data),
         .high  (high_q),
         .low   (low_q),
         .mode  (mode_i),
         .clr   (flag_clr[i]),
         .flag  (thr_flag[i])
      );
   end

   for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
      adc_seq_req i_req (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (en_q[s]),
         .eos_mode  (seq_mode[s]),
         .conv_done (res_vld && res_seq == 1'(s)),
         .seq_end   (seq_eos[s]),
         .req       (seq_irq[s])
      );
   end

   assign glob_hit = |(glob_ovr & ~seq_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovr_q <= 1'b0;
      else        ovr_q <= en_q[EN_OVR] && ((|chan_ovr) || glob_hit);
   end

   assign ovr_irq = ovr_q;
   assign thr_irq = |thr_flag;
endmodule

// File: rtl/adc_irq_gen_chk.sv
module adc_irq_gen_chk import adc_irq_pkg::*; #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned RES_W  = 12,
   parameter int unsigned REG_W  = 27,
   parameter int unsigned CH_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_vld,
   input logic [CH_W-1:0]   res_chan,
   input logic [RES_W-1:0]  res_data,
   input logic              res_seq,
   input logic [1:0]        seq_mode,
   input logic [1:0]        seq_eos,
   input logic [NUM_CH-1:0] chan_ovr,
   input logic [1:0]        glob_ovr,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [1:0]        seq_irq,
   input logic              ovr_irq,
   input logic [NUM_CH-1:0] thr_flag,
   input logic [REG_W-1:0]  en_q,
   input logic [RES_W-1:0]  high_q,
   input logic [RES_W-1:0]  low_q
);
   logic [1:0] fld;
   assign fld = en_q[EN_CMP_LSB + 2*int'(res_chan) +: 2];

   AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (int'(res_chan) < NUM_CH)); // R1

   AST_OUTSIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && fld == 2'd1 && (res_data > high_q || res_data < low_q))
      |=> thr_flag[$past(res_chan)]); // R2

   AST_IDLE_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && (fld == 2'd0 || fld == 2'd3) && !thr_flag[res_chan])
      |=> !thr_flag[$past(res_chan)]); // R4

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == A_FLAGS)
      |=> ((thr_flag & $past(thr_flag)) == $past(thr_flag))); // R5

   AST_SEQA_PER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[0] && !seq_mode[0] && res_vld && !res_seq) |=> seq_irq[0]); // R6

   AST_SEQB_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode[1] && !seq_eos[1]) |=> !seq_irq[1]); // R6

   AST_OVR_GLOBAL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_ovr == '0 && (glob_ovr & ~seq_mode) == 2'b00) |=> !ovr_irq); // R7

   AST_OVR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[EN_OVR] |=> !ovr_irq); // R7
endmodule

bind adc_irq_gen adc_irq_gen_chk #(
   .NUM_CH (NUM_CH),
   .RES_W  (RES_W),
   .REG_W  (REG_W),
   .CH_W   (CH_W)
) i_chk (.*);

// File: tb/test_adc_irq_gen.sv
module test_adc_irq_gen;
   localparam int NUM_CH = 12;
   localparam int RES_W  = 12;
   localparam int REG_W  = 27;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              res_vld = 1'b0;
   logic [3:0]        res_chan = '0;
   logic [RES_W-1:0]  res_data = '0;
   logic              res_seq = 1'b0;
   logic [1:0]        seq_mode = '0;
   logic [1:0]        seq_eos = '0;
   logic [NUM_CH-1:0] chan_ovr = '0;
   logic [1:0]        glob_ovr = '0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = '0;
   logic [REG_W-1:0]  wr_data = '0;
   logic [1:0]        seq_irq;
   logic              ovr_irq;
   logic              thr_irq;
   logic [NUM_CH-1:0] thr_flag;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   adc_irq_gen i_adc_irq_gen (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [REG_W-1:0] en_word(bit sa, bit sb, bit ov, int ch, logic [1:0] m);
      logic [REG_W-1:0] w = '0;
      w[0] = sa;
      w[1] = sb;
      w[2] = ov;
      if (ch >= 0) w[3 + 2*ch +: 2] = m;
      return w;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send(input int ch, input logic [RES_W-1:0] d, input logic sq);
      @(negedge clk);
      res_vld = 1'b1; res_chan = 4'(ch); res_data = d; res_seq = sq;
      @(negedge clk);
      res_vld = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 seq_irq", 32'(seq_irq), 0);
      chk("R1 ovr_irq", 32'(ovr_irq), 0);
      chk("R1 thr_irq", 32'(thr_irq), 0);
      chk("R1 thr_flag", 32'(thr_flag), 0);
   endtask

   task automatic t_outside;
      wr(2'd1, 27'h800);
      wr(2'd2, 27'h200);
      wr(2'd0, en_word(0, 0, 0, 3, 2'd1));
      send(3, 12'h800, 1'b0);
      chk("R2 equal high", 32'(thr_flag), 0);
      send(3, 12'h200, 1'b0);
      chk("R2 equal low", 32'(thr_flag), 0);
      send(3, 12'h801, 1'b0);
      chk("R2 above high", 32'(thr_flag), 32'h8);
      chk("R5 irq or", 32'(thr_irq), 1);
      wr(2'd3, 27'h0);
      chk("R5 write zero keeps", 32'(thr_flag), 32'h8);
      wr(2'd3, 27'h8);
      chk("R5 write one clears", 32'(thr_flag), 0);
      chk("R5 irq low", 32'(thr_irq), 0);
      send(3, 12'h1FF, 1'b1);
      chk("R8 below low from seq B", 32'(thr_flag), 32'h8);
      send(3, 12'h400, 1'b0);
      chk("R5 sticky after inside", 32'(thr_flag), 32'h8);
      // set and clear together: set wins
      @(negedge clk);
      res_vld = 1'b1; res_chan = 4'd3; res_data = 12'hFFF; res_seq = 1'b0;
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 27'h8;
      @(negedge clk);
      res_vld = 1'b0; wr_en = 1'b0;
      chk("R5 set wins", 32'(thr_flag), 32'h8);
      wr(2'd3, 27'hFFF);
   endtask

   task automatic t_cross;
      wr(2'd0, en_word(0, 0, 0, 5, 2'd2));
      send(5, 12'h100, 1'b1);
      chk("R3 first result history only", 32'(thr_flag), 0);
      send(5, 12'h300, 1'b1);
      chk("R3 upward crossing", 32'(thr_flag), 32'h20);
      wr(2'd3, 27'h20);
      send(5, 12'h900, 1'b0);
      chk("R3 no crossing above", 32'(thr_flag), 0);
      send(5, 12'h050, 1'b0);
      chk("R3 downward crossing", 32'(thr_flag), 32'h20);
      wr(2'd3, 27'hFFF);
   endtask

   task automatic t_history;
      wr(2'd0, en_word(0, 0, 0, 6, 2'd0));
      send(6, 12'h010, 1'b0);
      send(6, 12'hFFF, 1'b0);
      chk("R4 mode 0 no flag", 32'(thr_flag), 0);
      send(6, 12'h010, 1'b0);
      wr(2'd0, en_word(0, 0, 0, 6, 2'd2));
      send(6, 12'h300, 1'b0);
      chk("R3 history kept while off", 32'(thr_flag), 32'h40);
      wr(2'd3, 27'hFFF);
      wr(2'd0, en_word(0, 0, 0, 7, 2'd3));
      send(7, 12'hFFF, 1'b0);
      send(7, 12'h000, 1'b0);
      chk("R4 mode 3 no flag", 32'(thr_flag), 0);
   endtask

   task automatic t_seq;
      seq_mode = 2'b10;
      wr(2'd0, en_word(1, 1, 0, -1, 2'd0));
      send(3, 12'h400, 1'b0);
      chk("R6 A per conversion", 32'(seq_irq), 32'h1);
      @(negedge clk);
      chk("R6 A single pulse", 32'(seq_irq), 0);
      send(3, 12'h400, 1'b1);
      chk("R6 B ignores result in mode 1", 32'(seq_irq), 0);
      @(negedge clk);
      seq_eos = 2'b11;
      @(negedge clk);
      seq_eos = 2'b00;
      chk("R6 B on end, A not", 32'(seq_irq), 32'h2);
      wr(2'd0, en_word(0, 0, 0, -1, 2'd0));
      send(3, 12'h400, 1'b0);
      chk("R6 disabled", 32'(seq_irq), 0);
      seq_mode = 2'b00;
   endtask

   task automatic t_ovr;
      wr(2'd0, en_word(0, 0, 1, -1, 2'd0));
      @(negedge clk); chan_ovr = 12'h010;
      @(negedge clk); chan_ovr = '0;
      chk("R7 channel overrun", 32'(ovr_irq), 1);
      @(negedge clk); glob_ovr = 2'b01;
      @(negedge clk); glob_ovr = 2'b00;
      chk("R7 global overrun mode 0", 32'(ovr_irq), 1);
      seq_mode = 2'b01;
      @(negedge clk); glob_ovr = 2'b01;
      @(negedge clk); glob_ovr = 2'b00;
      chk("R7 global overrun mode 1 masked", 32'(ovr_irq), 0);
      seq_mode = 2'b00;
      wr(2'd0, en_word(0, 0, 0, -1, 2'd0));
      @(negedge clk); chan_ovr = 12'hFFF; glob_ovr = 2'b11;
      @(negedge clk); chan_ovr = '0; glob_ovr = 2'b00;
      chk("R7 overrun disabled", 32'(ovr_irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_outside();
      t_cross();
      t_history();
      t_seq();
      t_ovr();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule